// File: doc/BRIEF.md
# Windowed Watchdog Timer

A memory-mapped watchdog built around a 12-bit down-counter that advances once per pulse of a slow 256 Hz tick enable, so a reload value `t` gives a timeout of `(t+1)/256` seconds. Software keeps the system alive by writing a keyed restart command. The restart is only legal inside a window: the counter must already have fallen to or below a programmed window threshold. A restart that arrives too early, or a counter that runs out, is a fault.

Faults are latched in a status register that clears when read. Depending on configuration, a fault drives a level interrupt, a one-cycle reset request, or both. A separate configuration bit tells the reset network whether the request targets the processor only or the whole system. The configuration register accepts exactly one write after reset. A disable bit in it switches the watchdog off for good, and without that bit nothing can stop it. Two halt bits let external idle and debug indications freeze the counter.

Top module: `wdog_window_timer`

## Requirements
- R1: After reset the mode register (address 1) reads 0x3FFF2FFF, the status register (address 2) reads 0, the counter (address 3, bits 11:0) reads 0xFFF, and irq_o and rst_req_o are low.
- R2: The mode register takes only the first write after reset and ignores every later write. That first write also loads the counter from its bits 11:0.
- R3: On each tick_i cycle while running, the counter decrements by one.
- R4: A restart happens only on a write to address 0 with 0xA5 in bits 31:24 and bit 0 set. Any other control write has no effect.
- R5: A restart while the counter is at or below the window value (mode bits 27:16) reloads the counter from mode bits 11:0 and raises no fault.
- R6: A restart while the counter is above the window value also reloads the counter, and it sets the error flag (status bit 1).
- R7: A tick while the counter is 0 sets the underflow flag (status bit 0) and reloads the counter from mode bits 11:0.
- R8: A status read returns the flags and clears them in the same cycle. A fault in that same cycle stays set.
- R9: irq_o is high while any status flag is set and mode bit 12 (interrupt enable) is 1. Otherwise it is low.
- R10: In the cycle after a fault, rst_req_o pulses for one cycle if mode bit 13 (reset enable) is 1. rst_proc_o follows mode bit 14 (processor-only reset).
- R11: With mode bit 15 (disable) set, the counter holds its value, and restarts are ignored and raise no fault.
- R12: With mode bit 29 set, idle_i high freezes the counter. With mode bit 28 set, dbg_i high freezes it. With the bit clear, the input has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Bus access strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Register address: 0 control, 1 mode, 2 status, 3 counter |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of a read access |
| tick_i | input | 1 | 256 Hz count enable, one cycle wide |
| idle_i | input | 1 | Processor idle indication |
| dbg_i | input | 1 | Debug halt indication |
| irq_o | output | 1 | Fault interrupt, level |
| rst_req_o | output | 1 | Reset request pulse |
| rst_proc_o | output | 1 | Reset request targets the processor only |

## Verification
Restarts are placed on both sides of the window, at counter values above the threshold and at or below it, to separate a legal reload from an error fault. Sequences of ticks run through zero to show underflow and reload. Each is repeated with the halt inputs high and the halt bits set and clear, to separate frozen counting from running. A random phase mixes ticks, wrong-key and correct restarts, status and counter reads, and late mode writes against a cycle model. Its counter readback and per-cycle interrupt and reset checks expose off-by-one window comparisons, missing read-clear behaviour, and write-lock leaks.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
  localparam int CNT_W        = 12;
  localparam int DLT_LSB      = 16;
  localparam int IRQ_EN_BIT   = 12;
  localparam int RST_EN_BIT   = 13;
  localparam int PROC_BIT     = 14;
  localparam int DIS_BIT      = 15;
  localparam int DBG_HLT_BIT  = 28;
  localparam int IDLE_HLT_BIT = 29;
  localparam int KEY_LSB      = 24;
  localparam logic [31:0] MODE_RST = 32'h3FFF_2FFF;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_MODE = 2'd1,
    A_STAT = 2'd2,
    A_CNT  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/wdog_regs.sv
`timescale 1ns/1ps
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter logic [7:0] KEY = 8'hA5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [1:0]        flags_i,
  output logic [31:0]       rdata_o,
  output logic [31:0]       mode_o,
  output logic              locked_o,
  output logic              mode_wr_o,
  output logic              restart_o,
  output logic              stat_rd_o
);
  logic wr_en, rd_en;
  assign wr_en = sel_i & wr_i;
  assign rd_en = sel_i & ~wr_i;

  assign mode_wr_o = wr_en && addr_i == ADDR_W'(A_MODE) && !locked_o;
  assign restart_o = wr_en && addr_i == ADDR_W'(A_CTRL) &&
                     wdata_i[KEY_LSB +: 8] == KEY && wdata_i[0];
  assign stat_rd_o = rd_en && addr_i == ADDR_W'(A_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o   <= MODE_RST;
      locked_o <= 1'b0;
    end else if (mode_wr_o) begin
      mode_o   <= wdata_i;
      locked_o <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en) begin
      unique case (addr_i)
        ADDR_W'(A_MODE): rdata_o = mode_o;
        ADDR_W'(A_STAT): rdata_o = {30'd0, flags_i};
        ADDR_W'(A_CNT):  rdata_o = {{(32-CNT_W){1'b0}}, cnt_i};
        default:         rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/wdog_counter.sv
`timescale 1ns/1ps
module wdog_counter
  import wdog_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             idle_i,
  input  logic             dbg_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic [CNT_W-1:0] dlt_i,
  input  logic             dis_i,
  input  logic             idle_hlt_i,
  input  logic             dbg_hlt_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             restart_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             unf_o,
  output logic             err_o
);
  logic             run;
  logic [CNT_W-1:0] cnt_d;

  assign run = !dis_i && !(idle_i && idle_hlt_i) && !(dbg_i && dbg_hlt_i);

  always_comb begin
    cnt_d = cnt_o;
    unf_o = 1'b0;
    err_o = 1'b0;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (restart_i && !dis_i) begin
      err_o = cnt_o > dlt_i;   // restart outside the window
      cnt_d = val_i;
    end else if (tick_i && run) begin
      if (cnt_o == '0) begin
        unf_o = 1'b1;
        cnt_d = val_i;
      end else begin
        cnt_d = cnt_o - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= MODE_RST[CNT_W-1:0];
    else         cnt_o <= cnt_d;
  end
endmodule

// File: rtl/wdog_fault.sv
`timescale 1ns/1ps
module wdog_fault (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       unf_i,
  input  logic       err_i,
  input  logic       stat_rd_i,
  input  logic       irq_en_i,
  input  logic       rst_en_i,
  output logic [1:0] flags_o,
  output logic       irq_o,
  output logic       rst_req_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o   <= '0;
      rst_req_o <= 1'b0;
    end else begin
      // new events win over the read-clear
      flags_o   <= (flags_o & {2{~stat_rd_i}}) | {err_i, unf_i};
      rst_req_o <= rst_en_i & (unf_i | err_i);
    end
  end

  assign irq_o = irq_en_i & (|flags_o);
endmodule

// File: rtl/wdog_window_timer.sv
`timescale 1ns/1ps
module wdog_window_timer
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter logic [7:0] KEY = 8'hA5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              tick_i,
  input  logic              idle_i,
  input  logic              dbg_i,
  output logic              irq_o,
  output logic              rst_req_o,
  output logic              rst_proc_o
);
  logic [31:0]      mode_q;
  logic             locked, mode_wr, restart, stat_rd;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       flags;
  logic             unf, err;

  wdog_regs #(.ADDR_W(ADDR_W), .KEY(KEY)) i_regs (
    .clk_i, .rst_ni, .sel_i, .wr_i, .addr_i, .wdata_i,
    .cnt_i     (cnt),
    .flags_i   (flags),
    .rdata_o,
    .mode_o    (mode_q),
    .locked_o  (locked),
    .mode_wr_o (mode_wr),
    .restart_o (restart),
    .stat_rd_o (stat_rd)
  );

  wdog_counter i_counter (
    .clk_i, .rst_ni, .tick_i, .idle_i, .dbg_i,
    .val_i      (mode_q[CNT_W-1:0]),
    .dlt_i      (mode_q[DLT_LSB +: CNT_W]),
    .dis_i      (mode_q[DIS_BIT]),
    .idle_hlt_i (mode_q[IDLE_HLT_BIT]),
    .dbg_hlt_i  (mode_q[DBG_HLT_BIT]),
    .load_i     (mode_wr),
    .load_val_i (wdata_i[CNT_W-1:0]),
    .restart_i  (restart),
    .cnt_o      (cnt),
    .unf_o      (unf),
    .err_o      (err)
  );

  wdog_fault i_fault (
    .clk_i, .rst_ni,
    .unf_i     (unf),
    .err_i     (err),
    .stat_rd_i (stat_rd),
    .irq_en_i  (mode_q[IRQ_EN_BIT]),
    .rst_en_i  (mode_q[RST_EN_BIT]),
    .flags_o   (flags),
    .irq_o,
    .rst_req_o
  );

  assign rst_proc_o = mode_q[PROC_BIT];
endmodule

// File: rtl/wdog_window_timer_chk.sv
`timescale 1ns/1ps
module wdog_window_timer_chk
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              tick_i,
  input logic              idle_i,
  input logic              dbg_i,
  input logic              rst_req_o,
  input logic [31:0]       mode_q,
  input logic              locked,
  input logic              mode_wr,
  input logic              restart,
  input logic              stat_rd,
  input logic [CNT_W-1:0]  cnt,
  input logic [1:0]        flags
);
  logic run;
  assign run = !mode_q[DIS_BIT] && !(idle_i && mode_q[IDLE_HLT_BIT]) &&
               !(dbg_i && mode_q[DBG_HLT_BIT]);

  p_mode_locked_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked && sel_i && wr_i && addr_i == ADDR_W'(A_MODE)) |=> $stable(mode_q));

  p_early_err_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart && !mode_q[DIS_BIT] && cnt > mode_q[DLT_LSB +: CNT_W]) |=> flags[1]);

  p_underflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && run && !mode_wr && !restart && cnt == '0)
      |=> (flags[0] && cnt == $past(mode_q[CNT_W-1:0])));

  p_stat_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && !tick_i) |=> flags == 2'b00);

  p_rst_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked && !mode_q[RST_EN_BIT]) |=> !rst_req_o);

  p_disabled_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked && mode_q[DIS_BIT]) |=> ($stable(cnt) && !rst_req_o));

  p_idle_freeze_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && mode_q[IDLE_HLT_BIT] && !mode_wr && !restart) |=> $stable(cnt));
endmodule

bind wdog_window_timer wdog_window_timer_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i, .rst_ni, .sel_i, .wr_i, .addr_i, .tick_i, .idle_i, .dbg_i,
  .rst_req_o, .mode_q, .locked, .mode_wr, .restart, .stat_rd, .cnt, .flags
);

// File: tb/test_wdog_window_timer.sv
`timescale 1ns/1ps
module test_wdog_window_timer;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sel = 0, wr = 0, tick = 0, idle = 0, dbg = 0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq, rst_req, rst_proc;
  int          checks = 0, fails = 0;
  bit          done = 0;

  logic [31:0] m_mode;
  logic        m_lock;
  logic [11:0] m_cnt;
  logic [1:0]  m_flags;

  always #5 clk = ~clk;

  wdog_window_timer i_wdog_window_timer (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick), .idle_i(idle),
    .dbg_i(dbg), .irq_o(irq), .rst_req_o(rst_req), .rst_proc_o(rst_proc)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_rdata(input logic [1:0] a);
    case (a)
      2'd1: return m_mode;
      2'd2: return {30'd0, m_flags};
      2'd3: return {20'd0, m_cnt};
      default: return 32'd0;
    endcase
  endfunction

  task automatic do_reset();
    sel = 0; wr = 0; tick = 0; idle = 0; dbg = 0; addr = '0; wdata = '0;
    rst_n = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    m_mode = 32'h3FFF_2FFF; m_lock = 0; m_cnt = 12'hFFF; m_flags = 0;
  endtask

  // one bus/tick cycle; outputs checked against the model after the edge
  task automatic op(input logic s, input logic w, input logic [1:0] a,
                    input logic [31:0] d, input logic t, input logic il,
                    input logic dg, input string tag);
    logic mw, rs, rd_st, dis, run, e, u, exp_rst, exp_irq;
    logic [11:0] ncnt;
    logic [31:0] nmode;
    logic [1:0]  nflags;
    sel = s; wr = w; addr = a; wdata = d; tick = t; idle = il; dbg = dg;
    #3;
    if (s && !w) chk(tag, rdata, m_rdata(a));
    rd_st = s && !w && a == 2'd2;
    mw    = s && w && a == 2'd1 && !m_lock;
    rs    = s && w && a == 2'd0 && d[31:24] == 8'hA5 && d[0];
    dis   = m_mode[15];
    run   = !dis && !(il && m_mode[29]) && !(dg && m_mode[28]);
    e = 0; u = 0; ncnt = m_cnt; nmode = m_mode;
    if (mw) begin
      nmode = d; ncnt = d[11:0];
    end else if (rs && !dis) begin
      e = m_cnt > m_mode[27:16]; ncnt = m_mode[11:0];
    end else if (t && run) begin
      if (m_cnt == 0) begin u = 1; ncnt = m_mode[11:0]; end
      else ncnt = m_cnt - 1'b1;
    end
    exp_rst = m_mode[13] && (e || u);
    nflags  = (rd_st ? 2'b00 : m_flags) | {e, u};
    exp_irq = nmode[12] && (|nflags);
    @(posedge clk); #1;
    m_mode = nmode; m_cnt = ncnt; m_flags = nflags; m_lock = m_lock | mw;
    chk("R10 rst_req", {31'd0, rst_req}, {31'd0, exp_rst});
    chk("R9 irq", {31'd0, irq}, {31'd0, exp_irq});
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    op(1, 0, a, 0, 0, 0, 0, tag);
  endtask
  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    op(1, 1, a, d, 0, 0, 0, "WR");
  endtask
  task automatic ticks(input int n, input logic il, input logic dg);
    for (int i = 0; i < n; i++) op(0, 0, 0, 0, 1, il, dg, "TICK");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));

    // reset state
    do_reset();
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 rst_req", {31'd0, rst_req}, 32'd0);
    rd(2'd1, "R1 mode");
    chk("R1 mode value", m_mode, 32'h3FFF_2FFF);
    rd(2'd2, "R1 status");
    rd(2'd3, "R1 counter");
    // halts enabled by default
    ticks(3, 1, 0);
    rd(2'd3, "R12 idle freeze");
    chk("R12 idle freeze value", m_cnt, 32'hFFF);
    ticks(3, 0, 1);
    rd(2'd3, "R12 debug freeze");
    ticks(5, 0, 0);
    rd(2'd3, "R3 decrement");
    chk("R3 decrement value", {20'd0, m_cnt}, 32'hFFA);
    wr_reg(2'd0, 32'h5A00_0001);
    rd(2'd3, "R4 wrong key");
    wr_reg(2'd0, 32'hA500_0000);
    rd(2'd3, "R4 no restart bit");
    wr_reg(2'd0, 32'hA500_0001);
    rd(2'd3, "R5 legal restart reload");
    rd(2'd2, "R5 no fault");

    // window test: val 8, window 4, irq+rst+proc enabled, halts off
    do_reset();
    wr_reg(2'd1, 32'h0004_7008);
    rd(2'd1, "R2 first write");
    rd(2'd3, "R2 counter load");
    chk("R10 proc select", {31'd0, rst_proc}, 32'd1);
    wr_reg(2'd1, 32'h0000_0000);
    rd(2'd1, "R2 second write ignored");
    chk("R2 locked value", m_mode, 32'h0004_7008);
    ticks(2, 1, 1);
    rd(2'd3, "R12 halt bits off");
    wr_reg(2'd0, 32'hA500_0001);   // counter 6 > 4
    rd(2'd2, "R6 early restart error");
    rd(2'd2, "R8 read clears");
    ticks(4, 0, 0);                // 8 -> 4
    wr_reg(2'd0, 32'hA500_0001);   // at window edge
    rd(2'd2, "R5 restart at window");
    ticks(9, 0, 0);
    rd(2'd2, "R7 underflow flag");
    rd(2'd3, "R7 reload");

    // random phase
    for (int i = 0; i < 400; i++) begin
      int unsigned r;
      r = $urandom % 10;
      if (r < 6)
        op(0, 0, 0, 0, 1, 1'($urandom), 1'($urandom), "RND tick");
      else if (r == 6)
        op(1, 1, 0, (($urandom % 4) == 0) ? $urandom : 32'hA500_0001,
           1'($urandom), 0, 0, "RND restart");
      else if (r == 7)
        op(1, 0, 2, 0, 1'($urandom), 0, 0, "R8 RND status");
      else if (r == 8)
        op(1, 0, 3, 0, 0, 0, 0, "RND counter");
      else
        op(1, 1, 1, $urandom, 0, 0, 0, "R2 RND mode");
    end

    // disabled
    do_reset();
    wr_reg(2'd1, 32'h0000_A003);
    ticks(10, 0, 0);
    rd(2'd3, "R11 counter holds");
    wr_reg(2'd0, 32'hA500_0001);
    rd(2'd2, "R11 no fault");

    // faults with interrupt and reset disabled
    do_reset();
    wr_reg(2'd1, 32'h0000_0001);
    ticks(3, 0, 0);
    chk("R9 irq masked", {31'd0, irq}, 32'd0);
    rd(2'd2, "R7 underflow masked outputs");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule